// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block joins a single-rail datapath to a dual-rail one. On the sending side it turns a parallel word into dual-rail wire pairs. Each pair either carries one bit or sits at the empty code. On the receiving side it watches a dual-rail bus and combines the validity of every bit into one `done` signal. It also captures the word carried on the bus.

Validity is merged through a tree of two-input Muller C-element models. Each element is a clocked register that changes only when both of its inputs agree. The result is that `done` follows the four-phase handshake. It rises once the whole word carries data, and it stays high while bits drop back one at a time. It falls only once every pair has returned to empty. A pair that shows both wires high is flagged as a protocol error, and the flag stays set until reset.

Top module: `dr_completion`

## Requirements
- R1: While `enc_valid_i` is low, every wire of `enc_rails_o` is 0.
- R2: While `enc_valid_i` is high, pair i occupies `enc_rails_o[2i+1:2i]` as {high rail, low rail}. Bit value 0 is sent as 01 and bit value 1 as 10.
- R3: When every pair of `bus_rails_i` holds 01 or 10 and stays there, `done_o` goes high after L clock edges, where L = max(1, ceil(log2 WIDTH)) (L = 3 for WIDTH = 8).
- R4: While at least one pair is 00, `done_o` does not rise from low.
- R5: Once `done_o` is high, it stays high while some pairs return to 00 and others still carry data.
- R6: When every pair is 00 and stays there, `done_o` goes low after L clock edges.
- R7: A pair of 11 never counts as valid, so `done_o` does not rise while any pair is 11.
- R8: `err_o` goes high one clock edge after any pair of `bus_rails_i` is 11, and stays high until reset.
- R9: `dec_data_o` loads the high rail of every pair in the cycle where `done_o` first shows high, and is visible one edge later. At all other times it holds its value, even while the bus changes.
- R10: During and right after reset, `done_o`, `err_o` and `dec_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_data_i | input | WIDTH | Single-rail word to encode |
| enc_valid_i | input | 1 | High: encode the word; low: send empty code |
| enc_rails_o | output | 2*WIDTH | Encoded dual-rail pairs |
| bus_rails_i | input | 2*WIDTH | Dual-rail bus being watched |
| done_o | output | 1 | Completion, with hysteresis |
| dec_data_o | output | WIDTH | Word captured when completion rises |
| err_o | output | 1 | Sticky flag for a pair seen as 11 |

## Verification
A C-element node stuck at 1 or 0, or one that follows a single input, shows up at `done_o` as a rise that comes too early or too late. It can also show up as a drop while the bus is only half-way back to empty, or as a missing drop. Each of these appears within L edges of the input change that should have moved it. A capture register that loads at the wrong moment shows as `dec_data_o` following a later word one edge after the bus changes. A missing sticky bit shows as `err_o` clearing once the bad pair leaves the bus.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    PAIR_EMPTY = 2'b00,
    PAIR_ZERO  = 2'b01,
    PAIR_ONE   = 2'b10,
    PAIR_BAD   = 2'b11
  } pair_e;

  function automatic int tree_levels(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dr_encoder.sv
module dr_encoder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   data_i,
  input  logic               valid_i,
  output logic [2*WIDTH-1:0] rails_o
);
  import dr_pkg::*;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      if (!valid_i)       rails_o[2*i +: 2] = PAIR_EMPTY;
      else if (data_i[i]) rails_o[2*i +: 2] = PAIR_ONE;
      else                rails_o[2*i +: 2] = PAIR_ZERO;
    end
  end
endmodule

// File: rtl/dr_pair_check.sv
module dr_pair_check #(
  parameter int WIDTH = 8
) (
  input  logic [2*WIDTH-1:0] rails_i,
  output logic [WIDTH-1:0]   bit_valid_o,
  output logic [WIDTH-1:0]   bit_bad_o,
  output logic [WIDTH-1:0]   bit_high_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    logic lo, hi;
    assign lo = rails_i[2*i];
    assign hi = rails_i[2*i+1];
    // 11 is excluded from validity
    assign bit_valid_o[i] = lo ^ hi;
    assign bit_bad_o[i]   = lo & hi;
    assign bit_high_o[i]  = hi;
  end
endmodule

// File: rtl/dr_c_element.sv
module dr_c_element (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic z_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              z_o <= 1'b0;
    else if (a_i && b_i)      z_o <= 1'b1;
    else if (!a_i && !b_i)    z_o <= 1'b0;
  end
endmodule

// File: rtl/dr_c_tree.sv
module dr_c_tree #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] leaf_i,
  output logic         root_o
);
  localparam int LEVELS = dr_pkg::tree_levels(N);
  localparam int PAD    = 1 << LEVELS;

  // heap order: node 1 is root, leaves at PAD..2*PAD-1
  logic [2*PAD-1:1] node;

  for (genvar i = 0; i < PAD; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign node[PAD+i] = leaf_i[i];
    end else begin : g_pad
      assign node[PAD+i] = leaf_i[0];
    end
  end

  for (genvar j = 1; j < PAD; j++) begin : g_node
    dr_c_element i_c (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (node[2*j]),
      .b_i   (node[2*j+1]),
      .z_o   (node[j])
    );
  end

  assign root_o = node[1];
endmodule

// File: rtl/dr_decoder.sv
module dr_decoder #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [WIDTH-1:0] high_i,
  output logic [WIDTH-1:0] data_o
);
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      data_o <= '0;
    end else begin
      done_q <= done_i;
      if (done_i && !done_q) data_o <= high_i;
    end
  end
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   enc_data_i,
  input  logic               enc_valid_i,
  output logic [2*WIDTH-1:0] enc_rails_o,
  input  logic [2*WIDTH-1:0] bus_rails_i,
  output logic               done_o,
  output logic [WIDTH-1:0]   dec_data_o,
  output logic               err_o
);
  logic [WIDTH-1:0] bit_valid, bit_bad, bit_high;

  dr_encoder #(.WIDTH(WIDTH)) i_enc (
    .data_i (enc_data_i),
    .valid_i(enc_valid_i),
    .rails_o(enc_rails_o)
  );

  dr_pair_check #(.WIDTH(WIDTH)) i_pairs (
    .rails_i    (bus_rails_i),
    .bit_valid_o(bit_valid),
    .bit_bad_o  (bit_bad),
    .bit_high_o (bit_high)
  );

  dr_c_tree #(.N(WIDTH)) i_tree (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .leaf_i(bit_valid),
    .root_o(done_o)
  );

  dr_decoder #(.WIDTH(WIDTH)) i_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(done_o),
    .high_i(bit_high),
    .data_o(dec_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (|bit_bad) err_o <= 1'b1;
  end
endmodule

// File: rtl/dr_completion_chk.sv
module dr_completion_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [WIDTH-1:0]   enc_data_i,
  input logic               enc_valid_i,
  input logic [2*WIDTH-1:0] enc_rails_o,
  input logic [2*WIDTH-1:0] bus_rails_i,
  input logic               done_o,
  input logic [WIDTH-1:0]   dec_data_o,
  input logic               err_o
);
  localparam int LEVELS = dr_pkg::tree_levels(WIDTH);
  localparam int CW     = $clog2(LEVELS + 2) + 1;

  logic [WIDTH-1:0] lo, hi;
  for (genvar i = 0; i < WIDTH; i++) begin : g_split
    assign lo[i] = bus_rails_i[2*i];
    assign hi[i] = bus_rails_i[2*i+1];
  end

  logic all_full, all_empty, any_bad;
  assign all_full  = &(lo ^ hi);
  assign all_empty = ~|(lo | hi);
  assign any_bad   = |(lo & hi);

  logic [CW-1:0] run_full, run_empty;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_full  <= '0;
      run_empty <= '0;
    end else begin
      if (!all_full) run_full <= '0;
      else if (run_full < CW'(LEVELS)) run_full <= run_full + 1'b1;
      if (!all_empty) run_empty <= '0;
      else if (run_empty < CW'(LEVELS)) run_empty <= run_empty + 1'b1;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_enc
    a_r1_empty_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enc_valid_i |-> enc_rails_o[2*i +: 2] == 2'b00);
    a_r2_pair_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enc_valid_i |-> ($countones(enc_rails_o[2*i +: 2]) == 1 &&
                       enc_rails_o[2*i+1] == enc_data_i[i]));
  end

  a_r3_done_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_full == CW'(LEVELS) |-> done_o);

  a_r6_idle_after_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_empty == CW'(LEVELS) |-> !done_o);

  a_r8_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_bad |=> err_o);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |=> dec_data_o == $past(hi));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_o) |=> $stable(dec_data_o));
endmodule

bind dr_completion dr_completion_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enc_data_i (enc_data_i),
  .enc_valid_i(enc_valid_i),
  .enc_rails_o(enc_rails_o),
  .bus_rails_i(bus_rails_i),
  .done_o     (done_o),
  .dec_data_o (dec_data_o),
  .err_o      (err_o)
);

// File: tb/test_dr_completion.sv
`timescale 1ns/1ps
module test_dr_completion;
  localparam int W = 8;
  localparam int L = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [W-1:0]   enc_data_i = '0;
  logic           enc_valid_i = 1'b0;
  logic [2*W-1:0] enc_rails_o;
  logic [2*W-1:0] bus_rails_i = '0;
  logic           done_o;
  logic [W-1:0]   dec_data_o;
  logic           err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  dr_completion #(.WIDTH(W)) i_dr_completion (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enc_data_i (enc_data_i),
    .enc_valid_i(enc_valid_i),
    .enc_rails_o(enc_rails_o),
    .bus_rails_i(bus_rails_i),
    .done_o     (done_o),
    .dec_data_o (dec_data_o),
    .err_o      (err_o)
  );

  typedef struct {
    string          req;
    bit             use_enc;
    logic [2*W-1:0] enc;
    bit             use_out;
    logic           done;
    logic [W-1:0]   data;
    logic           err;
  } exp_t;

  exp_t sb[$];
  event chk_ev;

  function automatic logic [2*W-1:0] enc(input logic [W-1:0] d);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = d[i] ? 2'b10 : 2'b01;
    return r;
  endfunction

  // monitor: compares every queued expectation against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.use_enc) begin
          checks++;
          if (enc_rails_o !== e.enc) begin
            errors++;
            $display("FAIL %s rails act=%h exp=%h", e.req, enc_rails_o, e.enc);
          end
        end
        if (e.use_out) begin
          checks++;
          if (done_o !== e.done || dec_data_o !== e.data || err_o !== e.err) begin
            errors++;
            $display("FAIL %s done/data/err act=%b/%h/%b exp=%b/%h/%b",
                     e.req, done_o, dec_data_o, err_o, e.done, e.data, e.err);
          end
        end
      end
    end
  end

  task automatic expect_out(input string req, input logic d, input logic [W-1:0] q,
                            input logic e);
    exp_t x;
    x.req = req; x.use_enc = 0; x.enc = '0;
    x.use_out = 1; x.done = d; x.data = q; x.err = e;
    sb.push_back(x);
    -> chk_ev;
    #0.1;
  endtask

  task automatic expect_enc(input string req, input logic [2*W-1:0] r);
    exp_t x;
    x.req = req; x.use_enc = 1; x.enc = r;
    x.use_out = 0; x.done = 0; x.data = '0; x.err = 0;
    sb.push_back(x);
    -> chk_ev;
    #0.1;
  endtask

  // drive at negedge, then wait n edges and land back on a negedge
  task automatic drive_bus(input logic [2*W-1:0] r);
    @(negedge clk_i);
    bus_rails_i = r;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2*W-1:0] r;
    edges(3);
    expect_out("R10 in reset", 0, '0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    edges(2);
    expect_out("R10 after reset", 0, '0, 0);

    // encoder
    enc_data_i = 8'hA5; enc_valid_i = 1'b0; #1;
    expect_enc("R1 idle empty", '0);
    enc_valid_i = 1'b1; #1;
    expect_enc("R2 encode A5", enc(8'hA5));
    enc_data_i = 8'h0F; #1;
    expect_enc("R2 encode 0F", enc(8'h0F));
    enc_valid_i = 1'b0; #1;
    expect_enc("R1 back to empty", '0);

    // partial word: bit 7 empty
    r = enc(8'h3C); r[15:14] = 2'b00;
    drive_bus(r);
    edges(6);
    expect_out("R4 partial no done", 0, '0, 0);

    // full word
    drive_bus(enc(8'h3C));
    edges(L - 1);
    expect_out("R3 before latency", 0, '0, 0);
    edges(1);
    expect_out("R3 done up", 1, '0, 0);
    edges(1);
    expect_out("R9 captured 3C", 1, 8'h3C, 0);

    // new word while done high: capture holds
    drive_bus(enc(8'hFF));
    edges(5);
    expect_out("R9 holds while done high", 1, 8'h3C, 0);

    // half return to empty
    r = enc(8'hFF); r[7:0] = '0;
    drive_bus(r);
    edges(6);
    expect_out("R5 hysteresis", 1, 8'h3C, 0);

    // full return
    drive_bus('0);
    edges(L - 1);
    expect_out("R6 before latency", 1, 8'h3C, 0);
    edges(1);
    expect_out("R6 done down", 0, 8'h3C, 0);

    // second handshake
    drive_bus(enc(8'h81));
    edges(L + 1);
    expect_out("R3 second word", 1, 8'h81, 0);
    drive_bus('0);
    edges(L + 2);
    expect_out("R6 second return", 0, 8'h81, 0);

    // illegal pair
    r = enc(8'h55); r[5:4] = 2'b11;
    drive_bus(r);
    edges(1);
    expect_out("R8 err set", 0, 8'h81, 1);
    edges(6);
    expect_out("R7 bad pair not valid", 0, 8'h81, 1);
    drive_bus('0);
    edges(5);
    expect_out("R8 err sticky", 0, 8'h81, 1);

    // reset clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    expect_out("R10 reset clears", 0, '0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    edges(2);
    expect_out("R10 stays clear", 0, '0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule